// File: doc/BRIEF.md
# Register-Mapped SPI Byte Master

This block is an SPI master that sits on a simple word register bus. Software selects one or more slaves through a mask register. A byte written to the transmit word is held in a one-deep holding register until the shifter is free. The shifter then runs one full-duplex frame in mode 0: the clock idles low, the outgoing line changes on falling edges, and the incoming line is sampled on rising edges, most significant bit first. The received byte lands in a one-deep receive register.

Status flags report when the holding register can accept a byte and when the shifter is idle. They also report that a received byte is waiting, that a write or a received byte was lost, and a summary of any loss. A control word holds per-flag interrupt enables and a bit that keeps the selected slave lines asserted between frames, so that a multi-byte command to a flash device stays framed. Register reads return data one cycle after the read strobe. The interrupt output is registered.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the slave-select lines are all high, the serial clock is low, the interrupt is low, the status word reads 0x060 (transmit ready at bit 6 and shifter empty at bit 5) and the control word reads 0.
- R2: A write to byte offset 4 starts one 8-bit frame: the serial clock idles low, the outgoing line changes only after falling edges, and a slave sampling on rising edges receives the written byte MSB first.
- R3: The incoming line is sampled on rising edges MSB first; after the frame the byte reads back at offset 0 and status bit 7 (receive ready) is set.
- R4: A read of offset 0 clears receive ready. A frame that completes while receive ready is set, with no read in that cycle, sets status bit 3 (receive overrun), and offset 0 then holds the newest byte.
- R5: With the force bit clear, a slave whose mask bit is set is driven low only while a frame shifts, with ss_n equal to the inverted mask during the frame and all high once it ends.
- R6: Status bit 6 is high while the holding register is empty. A transmit write while it is low sets status bit 4 (transmit overrun) and the byte is dropped, so it never appears on the serial line.
- R7: Any write to byte offset 8 clears both overrun flags.
- R8: Status bit 8 equals the OR of the two overrun flags.
- R9: The interrupt output, one cycle after the status changes, is the OR over bits 3, 4, 6, 7 and 8 of the status bit ANDed with the control bit at the same position (control at byte offset 12).
- R10: While control bit 10 (force) is set, the masked slave lines stay low between frames. Clearing it during a frame keeps them low until that frame ends, after which they go high.
- R11: The mask register at byte offset 20 reads back as written, with bit n driving ss_n[n]. A mask of 0 keeps every ss_n line high during a frame.
- R12: If the receive word is read in the same cycle that a frame completes, the read returns the older byte, receive ready stays set, and receive overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSLAVES | Active-low slave selects |

## Verification
Two events can fall in the same cycle: the completion of a frame, which writes the receive register, and a software read of that register. The bench counts eight falling serial-clock edges of a frame and raises the read strobe just after the eighth. The strobe is then sampled on exactly the clock edge where the finished byte lands. The read must return the previous byte, and the status that follows must show receive ready set with no overrun. A second read must then return the new byte.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  // word indices (byte offset / 4)
  localparam logic [2:0] WIDX_RX   = 3'd0;
  localparam logic [2:0] WIDX_TX   = 3'd1;
  localparam logic [2:0] WIDX_STAT = 3'd2;
  localparam logic [2:0] WIDX_CTRL = 3'd3;
  localparam logic [2:0] WIDX_SEL  = 3'd5;

  // status / control bit positions
  localparam int B_ROE   = 3;
  localparam int B_TOE   = 4;
  localparam int B_TMT   = 5;
  localparam int B_TRDY  = 6;
  localparam int B_RRDY  = 7;
  localparam int B_ERR   = 8;
  localparam int B_FORCE = 10;

  localparam logic [31:0] IRQ_MASK  = (32'd1 << B_ROE) | (32'd1 << B_TOE) |
                                      (32'd1 << B_TRDY) | (32'd1 << B_RRDY) |
                                      (32'd1 << B_ERR);
  localparam logic [31:0] CTRL_MASK = IRQ_MASK | (32'd1 << B_FORCE);
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int FRAME_W  = 8,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] start_data,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               sclk,
  output logic               mosi
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_cnt;

  assign mosi = tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      cnt     <= '0;
      bit_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          tx_sh   <= start_data;
          cnt     <= '0;
          bit_cnt <= '0;
          sclk    <= 1'b0;
        end
      end else if (cnt == CNT_W'(HALF_DIV - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // mode 0: data out must not move at a rising clock edge
  assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_master_pkg::*;
#(
  parameter int NSLAVES = 32,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               eng_busy,
  input  logic               eng_done,
  input  logic [FRAME_W-1:0] eng_rx,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_byte,
  output logic [NSLAVES-1:0] sel_mask,
  output logic               force_sel,
  output logic               irq
);
  logic [2:0]         widx;
  logic               tx_full, rrdy, roe, toe;
  logic [FRAME_W-1:0] tx_hold, rx_hold;
  logic [31:0]        ctrl_q, status_w;
  logic [NSLAVES-1:0] sel_q;
  logic               wr_tx, wr_stat, wr_ctrl, wr_sel, rd_rx;
  logic               drop_tx, lose_rx;

  assign widx    = reg_addr[4:2];
  assign wr_tx   = reg_wr && (widx == WIDX_TX);
  assign wr_stat = reg_wr && (widx == WIDX_STAT);
  assign wr_ctrl = reg_wr && (widx == WIDX_CTRL);
  assign wr_sel  = reg_wr && (widx == WIDX_SEL);
  assign rd_rx   = reg_rd && (widx == WIDX_RX);
  assign drop_tx = wr_tx && tx_full;
  assign lose_rx = eng_done && rrdy && !rd_rx;

  assign tx_start  = tx_full && !eng_busy;
  assign tx_byte   = tx_hold;
  assign sel_mask  = sel_q;
  assign force_sel = ctrl_q[B_FORCE];

  always_comb begin
    status_w         = '0;
    status_w[B_ROE]  = roe;
    status_w[B_TOE]  = toe;
    status_w[B_TMT]  = !tx_full && !eng_busy;
    status_w[B_TRDY] = !tx_full;
    status_w[B_RRDY] = rrdy;
    status_w[B_ERR]  = roe | toe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full   <= 1'b0;
      tx_hold   <= '0;
      rx_hold   <= '0;
      rrdy      <= 1'b0;
      roe       <= 1'b0;
      toe       <= 1'b0;
      ctrl_q    <= '0;
      sel_q     <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (tx_start) tx_full <= 1'b0;
      if (wr_tx && !tx_full) begin
        tx_full <= 1'b1;
        tx_hold <= reg_wdata[FRAME_W-1:0];
      end

      if (eng_done) begin
        rx_hold <= eng_rx;
        rrdy    <= 1'b1;
      end else if (rd_rx) begin
        rrdy <= 1'b0;
      end

      if (lose_rx)      roe <= 1'b1;
      else if (wr_stat) roe <= 1'b0;
      if (drop_tx)      toe <= 1'b1;
      else if (wr_stat) toe <= 1'b0;

      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      if (wr_sel)  sel_q  <= reg_wdata[NSLAVES-1:0];

      if (reg_rd) begin
        case (widx)
          WIDX_RX:   reg_rdata <= 32'(rx_hold);
          WIDX_STAT: reg_rdata <= status_w;
          WIDX_CTRL: reg_rdata <= ctrl_q;
          WIDX_SEL:  reg_rdata <= 32'(sel_q);
          default:   reg_rdata <= '0;
        endcase
      end

      irq <= |(status_w & ctrl_q & IRQ_MASK);
    end
  end

  assert_toe_on_drop_R6: assert property (@(posedge clk) disable iff (rst)
    wr_tx && tx_full |=> toe);
  assert_roe_on_loss_R4: assert property (@(posedge clk) disable iff (rst)
    eng_done && rrdy && !rd_rx |=> roe);
  assert_read_meets_done_R12: assert property (@(posedge clk) disable iff (rst)
    eng_done && rd_rx |=> rrdy && (roe == $past(roe)));
  assert_stat_clear_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stat && !lose_rx && !drop_tx |=> !roe && !toe);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int NSLAVES  = 32,
  parameter int FRAME_W  = 8,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NSLAVES-1:0] ss_n
);
  logic               eng_busy, eng_done, tx_start, force_sel;
  logic [FRAME_W-1:0] eng_rx, tx_byte;
  logic [NSLAVES-1:0] sel_mask;

  spi_reg_bank #(.NSLAVES(NSLAVES), .FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_rx(eng_rx), .tx_start(tx_start), .tx_byte(tx_byte),
    .sel_mask(sel_mask), .force_sel(force_sel), .irq(irq)
  );

  spi_shift_engine #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst(rst), .start(tx_start), .start_data(tx_byte), .miso(miso),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) ss_n <= '1;
    else     ss_n <= ~(sel_mask & {NSLAVES{eng_busy | force_sel}});
  end

  assert_ss_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (ss_n != '1) |-> ($past(eng_busy) || $past(force_sel)));
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  localparam int HALF = 2;
  localparam int NS   = 32;
  localparam int FRAME_CYC = 16 * HALF + 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk, mosi, miso;
  logic [NS-1:0] ss_n;

  int errors = 0, checks = 0;
  int slave_idx = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slv_sh;

  always #2.5 clk = ~clk;

  spi_byte_master #(.NSLAVES(NS), .FRAME_W(8), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  function automatic logic [7:0] slave_byte(int k);
    return 8'h3C + 8'(17 * k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model: shifts out on falling edges, reloads after each frame
  assign miso = slv_sh[7];
  initial begin
    int falls = 0;
    slv_sh = slave_byte(0);
    forever begin
      @(negedge sclk);
      if (falls == 7) begin
        falls = 0;
        slave_idx++;
        slv_sh = slave_byte(slave_idx);
      end else begin
        falls++;
        slv_sh = {slv_sh[6:0], 1'b0};
      end
    end
  end

  // monitor: collects bytes seen by the slave and compares with the scoreboard (R2)
  initial begin
    logic [7:0] got = '0;
    int rises = 0;
    forever begin
      @(posedge sclk);
      got = {got[6:0], mosi};
      rises++;
      if (rises == 8) begin
        rises = 0;
        if (exp_q.size() == 0) chk("R2 unexpected frame", 32'(got), 32'hFFFF);
        else chk("R2 mosi byte", 32'(got), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    exp_q.push_back(b);
    wr(5'd4, 32'(b));
  endtask

  task automatic wait_frame();
    repeat (FRAME_CYC) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 ss_n", ss_n, '1);
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(5'd8, v);  chk("R1 status", v, 32'h060);
    rd(5'd12, v); chk("R1 control", v, 0);
    // R11 mask readback
    wr(5'd20, 32'h8);
    rd(5'd20, v); chk("R11 mask readback", v, 32'h8);
    // R2/R3/R5 first frame
    send(8'hA5);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R5 ss during frame", ss_n, ~32'h8);
    wait_frame();
    chk("R5 ss after frame", ss_n, '1);
    rd(5'd8, v); chk("R3 rrdy set", v, 32'h0E0);
    rd(5'd0, v); chk("R3 rx byte", v, 32'(slave_byte(0)));
    rd(5'd8, v); chk("R4 rrdy cleared", v, 32'h060);
    // R11 mask zero
    wr(5'd20, 32'h0);
    send(8'h81);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R11 no select", ss_n, '1);
    wait_frame();
    rd(5'd0, v); chk("R3 rx byte 2", v, 32'(slave_byte(1)));
    wr(5'd20, 32'h8);
    // R4/R8 receive overrun
    send(8'h12); wait_frame();
    send(8'h34); wait_frame();
    rd(5'd8, v); chk("R4 R8 overrun status", v, 32'h1E8);
    rd(5'd0, v); chk("R4 newest byte", v, 32'(slave_byte(3)));
    wr(5'd8, 32'h0);
    rd(5'd8, v); chk("R7 cleared", v, 32'h060);
    // R6 transmit overrun
    send(8'h5A);
    repeat (3) @(posedge clk);
    send(8'hC3);
    wr(5'd4, 32'hEE);           // dropped
    rd(5'd8, v); chk("R6 R8 toe status", v, 32'h110);
    wait_frame(); wait_frame();
    chk("R6 dropped byte absent", 32'(exp_q.size()), 0);
    rd(5'd0, v); chk("R4 rx after toe", v, 32'(slave_byte(5)));
    wr(5'd8, 32'h0);
    // R9 interrupt
    wr(5'd12, 32'h80);
    @(negedge clk); chk("R9 irq idle", 32'(irq), 0);
    send(8'h66); wait_frame();
    chk("R9 irq rrdy", 32'(irq), 1);
    rd(5'd0, v);
    @(negedge clk); chk("R9 irq cleared", 32'(irq), 0);
    wr(5'd12, 32'h40);
    @(negedge clk); chk("R9 irq trdy", 32'(irq), 1);
    wr(5'd12, 32'h0);
    // R10 force select
    wr(5'd12, 32'h400);
    @(negedge clk); chk("R10 forced idle", ss_n, ~32'h8);
    send(8'h01); wait_frame();
    chk("R10 held between frames", ss_n, ~32'h8);
    send(8'h02);
    repeat (4) @(posedge clk);
    wr(5'd12, 32'h0);
    @(negedge clk); chk("R10 held to frame end", ss_n, ~32'h8);
    wait_frame();
    chk("R10 released", ss_n, '1);
    rd(5'd0, v); chk("R3 rx forced", v, 32'(slave_byte(8)));
    wr(5'd8, 32'h0);
    // R12 read in the completion cycle
    send(8'h77); wait_frame();
    send(8'h88);
    repeat (8) @(negedge sclk);
    #1; reg_addr = 5'd0; reg_rd = 1'b1;
    @(posedge clk); #1; reg_rd = 1'b0;
    @(negedge clk); chk("R12 old byte", reg_rdata, 32'(slave_byte(9)));
    rd(5'd8, v); chk("R12 rrdy kept no roe", v, 32'h0E0);
    rd(5'd0, v); chk("R12 new byte", v, 32'(slave_byte(10)));
    repeat (4) @(posedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule